// File: doc/BRIEF.md
# Home Directory Controller for a Four-State Ownership Protocol

This block is the home node for a small range of memory blocks in a directory-based coherence scheme that runs over an unordered point-to-point network. It records for every block a stable directory state, the identity of the owning cache and a bit vector of caches that hold read-only copies, and it holds the block data in a small register file. Caches send it unicast requests: read (GetS), write (GetM), and three kinds of release (PutS for a read-only copy, PutM for a modified copy, PutO for an owned copy). A separate port carries the data that a former owner writes back after a forwarded read.

For each request the controller issues one message one cycle later. That message is a data response with an acknowledgement count, a forwarded read or write sent to the owner, a release acknowledgement, or an acknowledgement count alone when the owner upgrades. The invalidation set travels as a bit vector beside the message. The directory states are I (no cache copy, home owns), S (read-only copies, home owns), O (a cache owns, others may share), M (one cache holds it writable) and SD (a former modified owner must write data back). Named transitions: I/S-read-serve, I/S-write-serve, M-read-forward (to SD, or to O when the parameter `KEEP_OWNER` is 1), SD-writeback-settle (to S), O-read-forward, O-write-forward, O-owner-upgrade, M-write-forward, sharer-release (S to I on the last sharer), modified-release (M to I) and owned-release (O to S or I). A request for a block in SD is parked in a small queue. The queue replays it after the block settles.

Top module: `dir_home_top`

## Requirements
- R1: After reset every block is in I, block b holds the bitwise complement of b, out_valid is 0 and req_ready is 1.
- R2: A GetS (req_kind 0) to a block in I or S yields, one cycle after acceptance, a data response (out_kind 0) to the requester carrying the memory value, with out_acks 0 and out_inv 0. The requester joins the sharers and the block rests in S.
- R3: With KEEP_OWNER 0, a GetS to a block in M is forwarded to the owner as out_kind 1, and the block enters SD with the owner and the requester as sharers. A writeback from the recorded owner moves it to S and stores the data. A writeback from any other cache, or to a block not in SD, changes nothing and emits no message.
- R4: A request to a block in SD produces no message and is queued. Queued requests replay in arrival order, one per cycle, starting the cycle after the block leaves SD. req_ready is 0 while the queue is full or a replay is being served.
- R5: With KEEP_OWNER 1, a GetS to a block in M or O is forwarded to the owner as out_kind 1. The block stays in, or enters, O and the requester is added as a sharer.
- R6: A GetM (req_kind 1) to a block in I or S returns a data response whose out_inv has bit i set for every sharer i other than the requester, and whose out_acks is the number of those bits. The block becomes M with the requester as owner.
- R7: A GetM to a block in O from a cache other than the owner is forwarded to the owner as out_kind 2. From the owner itself it yields an acknowledgement count message (out_kind 4). In both cases out_inv and out_acks cover the sharers other than the requester, and the block becomes M owned by the requester.
- R8: A GetM to a block in M is forwarded to the current owner as out_kind 2 with out_acks 0, and ownership passes to the requester.
- R9: A PutS (req_kind 2) from a recorded sharer is acknowledged with out_kind 3 and removes that sharer. If the block is in S and that sharer was the last one, the block returns to I.
- R10: A PutM (req_kind 3) from the owner of a block in M, or a PutO (req_kind 4) from the owner of a block in O, writes req_data to memory and is acknowledged with out_kind 3. M goes to I; O goes to S if sharers remain, else to I.
- R11: A release from a cache that is not the recorded owner or sharer in the matching state is still acknowledged with out_kind 3, but changes neither state nor memory.
- R12: In every message out_acks equals the number of set bits of out_inv, and a data response never invalidates its own destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_kind | input | 3 | 0 GetS, 1 GetM, 2 PutS, 3 PutM, 4 PutO |
| req_src | input | $clog2(NCACHE) | Requesting cache |
| req_addr | input | $clog2(NBLK) | Block index |
| req_data | input | DW | Data carried by PutM or PutO |
| wb_valid | input | 1 | Writeback after a forwarded read |
| wb_src | input | $clog2(NCACHE) | Cache sending the writeback |
| wb_addr | input | $clog2(NBLK) | Block of the writeback |
| wb_data | input | DW | Written-back value |
| out_valid | output | 1 | Message issued |
| out_kind | output | 3 | 0 data, 1 fwd read, 2 fwd write, 3 release ack, 4 ack count |
| out_dst | output | $clog2(NCACHE) | Destination cache |
| out_addr | output | $clog2(NBLK) | Block index |
| out_acks | output | $clog2(NCACHE+1) | Acknowledgements the requester must collect |
| out_inv | output | NCACHE | Caches to invalidate, bit i for cache i |
| out_data | output | DW | Block data for a data response, else 0 |

## Verification
Two instances that differ only in KEEP_OWNER receive the same request stream, so the write-back path and the ownership-retaining path are compared cycle by cycle against arithmetic expectations. The bench targets several failure modes. If the ack count were not filtered to exclude the requester, upgrades from a sharer would over-count. If stale releases mutated state, a later write would miss or add an invalidation. If the last-sharer test were wrong, a block would linger in S and invalidate a cache that already released it. If the writeback owner check were missing, a stray writeback from a non-owner would settle SD with the wrong data. Filling the parking queue shows whether back-pressure rises, and whether the parked reads replay in order with the written-back value rather than the stale one.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [2:0] {
        DS_I  = 3'd0,
        DS_S  = 3'd1,
        DS_O  = 3'd2,
        DS_M  = 3'd3,
        DS_SD = 3'd4
    } dstate_e;

    localparam logic [2:0] RQ_GETS = 3'd0;
    localparam logic [2:0] RQ_GETM = 3'd1;
    localparam logic [2:0] RQ_PUTS = 3'd2;
    localparam logic [2:0] RQ_PUTM = 3'd3;
    localparam logic [2:0] RQ_PUTO = 3'd4;

    localparam logic [2:0] MS_DATA     = 3'd0;
    localparam logic [2:0] MS_FWD_GETS = 3'd1;
    localparam logic [2:0] MS_FWD_GETM = 3'd2;
    localparam logic [2:0] MS_PUT_ACK  = 3'd3;
    localparam logic [2:0] MS_ACK_CNT  = 3'd4;

endpackage

// File: rtl/dir_pend_q.sv
module dir_pend_q #(
    parameter int DEPTH = 2,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int NW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  slot [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [NW-1:0] fill;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign dout  = slot[rd_ptr];
    assign empty = (fill == '0);
    assign full  = (fill == NW'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            fill   <= '0;
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else begin
            if (push && !full) begin
                slot[wr_ptr] <= din;
                wr_ptr       <= bump(wr_ptr);
            end
            if (pop && !empty) rd_ptr <= bump(rd_ptr);
            case ({push && !full, pop && !empty})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/dir_serve.sv
module dir_serve
    import dir_pkg::*;
#(
    parameter int NCACHE     = 4,
    parameter int DW         = 8,
    parameter int KEEP_OWNER = 0,
    localparam int IDW       = $clog2(NCACHE),
    localparam int CW        = $clog2(NCACHE + 1)
) (
    input  dstate_e           cur_st,
    input  logic [IDW-1:0]    cur_own,
    input  logic [NCACHE-1:0] cur_shr,
    input  logic [DW-1:0]     cur_mem,
    input  logic [2:0]        kind,
    input  logic [IDW-1:0]    src,
    input  logic [DW-1:0]     wdata,
    output dstate_e           nxt_st,
    output logic [IDW-1:0]    nxt_own,
    output logic [NCACHE-1:0] nxt_shr,
    output logic              mem_we,
    output logic [DW-1:0]     mem_wd,
    output logic              m_valid,
    output logic [2:0]        m_kind,
    output logic [IDW-1:0]    m_dst,
    output logic [CW-1:0]     m_acks,
    output logic [NCACHE-1:0] m_inv,
    output logic [DW-1:0]     m_data
);
    logic [NCACHE-1:0] req_bit, own_bit, others;
    dstate_e           share_st;
    logic [NCACHE-1:0] share_keep;

    assign req_bit = NCACHE'(1) << src;
    assign own_bit = NCACHE'(1) << cur_own;
    assign others  = cur_shr & ~req_bit;

    // The parameter picks what a read does to a modified block.
    if (KEEP_OWNER != 0) begin : g_keep
        assign share_st   = DS_O;
        assign share_keep = '0;
    end else begin : g_wback
        assign share_st   = DS_SD;
        assign share_keep = own_bit;
    end

    always_comb begin
        nxt_st  = cur_st;
        nxt_own = cur_own;
        nxt_shr = cur_shr;
        mem_we  = 1'b0;
        mem_wd  = wdata;
        m_valid = 1'b1;
        m_kind  = MS_PUT_ACK;
        m_dst   = src;
        m_acks  = '0;
        m_inv   = '0;
        m_data  = '0;
        case (kind)
            RQ_GETS: begin
                case (cur_st)
                    DS_I, DS_S: begin
                        m_kind  = MS_DATA;
                        m_data  = cur_mem;
                        nxt_shr = cur_shr | req_bit;
                        nxt_st  = DS_S;
                    end
                    DS_O: begin
                        m_kind  = MS_FWD_GETS;
                        m_dst   = cur_own;
                        nxt_shr = cur_shr | req_bit;
                    end
                    DS_M: begin
                        m_kind  = MS_FWD_GETS;
                        m_dst   = cur_own;
                        nxt_shr = cur_shr | req_bit | share_keep;
                        nxt_st  = share_st;
                    end
                    default: m_valid = 1'b0;
                endcase
            end
            RQ_GETM: begin
                case (cur_st)
                    DS_I, DS_S: begin
                        m_kind  = MS_DATA;
                        m_data  = cur_mem;
                        m_inv   = others;
                        m_acks  = CW'($countones(others));
                        nxt_st  = DS_M;
                        nxt_own = src;
                        nxt_shr = '0;
                    end
                    DS_O: begin
                        m_kind  = (cur_own == src) ? MS_ACK_CNT : MS_FWD_GETM;
                        m_dst   = (cur_own == src) ? src : cur_own;
                        m_inv   = others;
                        m_acks  = CW'($countones(others));
                        nxt_st  = DS_M;
                        nxt_own = src;
                        nxt_shr = '0;
                    end
                    DS_M: begin
                        m_kind  = MS_FWD_GETM;
                        m_dst   = cur_own;
                        nxt_own = src;
                    end
                    default: m_valid = 1'b0;
                endcase
            end
            RQ_PUTS: begin
                if ((cur_st == DS_S || cur_st == DS_O) && (cur_shr & req_bit) != '0) begin
                    nxt_shr = others;
                    if (cur_st == DS_S && others == '0) nxt_st = DS_I;
                end
            end
            RQ_PUTM: begin
                if (cur_st == DS_M && cur_own == src) begin
                    mem_we  = 1'b1;
                    nxt_st  = DS_I;
                    nxt_shr = '0;
                end
            end
            RQ_PUTO: begin
                if (cur_st == DS_O && cur_own == src) begin
                    mem_we = 1'b1;
                    nxt_st = (cur_shr != '0) ? DS_S : DS_I;
                end
            end
            default: m_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/dir_home_top.sv
module dir_home_top
    import dir_pkg::*;
#(
    parameter int NCACHE     = 4,
    parameter int NBLK       = 4,
    parameter int DW         = 8,
    parameter int QDEPTH     = 2,
    parameter int KEEP_OWNER = 0,
    localparam int IDW       = $clog2(NCACHE),
    localparam int AW        = $clog2(NBLK),
    localparam int CW        = $clog2(NCACHE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [IDW-1:0]    req_src,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_data,
    input  logic              wb_valid,
    input  logic [IDW-1:0]    wb_src,
    input  logic [AW-1:0]     wb_addr,
    input  logic [DW-1:0]     wb_data,
    output logic              out_valid,
    output logic [2:0]        out_kind,
    output logic [IDW-1:0]    out_dst,
    output logic [AW-1:0]     out_addr,
    output logic [CW-1:0]     out_acks,
    output logic [NCACHE-1:0] out_inv,
    output logic [DW-1:0]     out_data
);
    localparam int RW = 3 + IDW + AW + DW;

    dstate_e           st_q  [NBLK];
    logic [IDW-1:0]    own_q [NBLK];
    logic [NCACHE-1:0] shr_q [NBLK];
    logic [DW-1:0]     mem_q [NBLK];

    logic          q_empty, q_full, replay, take, park, serve_go, wb_hit;
    logic [RW-1:0] q_dout;
    dstate_e       req_st;

    logic [2:0]     sel_kind;
    logic [IDW-1:0] sel_src;
    logic [AW-1:0]  sel_addr;
    logic [DW-1:0]  sel_data;

    dstate_e           nxt_st;
    logic [IDW-1:0]    nxt_own, m_dst;
    logic [NCACHE-1:0] nxt_shr, m_inv;
    logic              mem_we, m_valid;
    logic [DW-1:0]     mem_wd, m_data;
    logic [2:0]        m_kind;
    logic [CW-1:0]     m_acks;

    assign req_st    = st_q[req_addr];
    assign replay    = !q_empty && (st_q[q_dout[AW+DW-1:DW]] != DS_SD);
    assign req_ready = !q_full && !replay;
    assign take      = req_valid && req_ready;
    assign park      = take && (req_st == DS_SD);
    assign serve_go  = replay || (take && !park);
    assign wb_hit    = wb_valid && (st_q[wb_addr] == DS_SD) && (own_q[wb_addr] == wb_src);

    always_comb begin
        if (replay) {sel_kind, sel_src, sel_addr, sel_data} = q_dout;
        else        {sel_kind, sel_src, sel_addr, sel_data} = {req_kind, req_src, req_addr, req_data};
    end

    dir_pend_q #(.DEPTH(QDEPTH), .W(RW)) u_park (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (park),
        .pop   (replay),
        .din   ({req_kind, req_src, req_addr, req_data}),
        .dout  (q_dout),
        .empty (q_empty),
        .full  (q_full)
    );

    dir_serve #(.NCACHE(NCACHE), .DW(DW), .KEEP_OWNER(KEEP_OWNER)) u_serve (
        .cur_st  (st_q[sel_addr]),
        .cur_own (own_q[sel_addr]),
        .cur_shr (shr_q[sel_addr]),
        .cur_mem (mem_q[sel_addr]),
        .kind    (sel_kind),
        .src     (sel_src),
        .wdata   (sel_data),
        .nxt_st  (nxt_st),
        .nxt_own (nxt_own),
        .nxt_shr (nxt_shr),
        .mem_we  (mem_we),
        .mem_wd  (mem_wd),
        .m_valid (m_valid),
        .m_kind  (m_kind),
        .m_dst   (m_dst),
        .m_acks  (m_acks),
        .m_inv   (m_inv),
        .m_data  (m_data)
    );

    // Directory state register. A served block is never in SD and a
    // writeback only lands on an SD block, so the two never collide.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBLK; b++) begin
                st_q[b]  <= DS_I;
                own_q[b] <= '0;
                shr_q[b] <= '0;
                mem_q[b] <= ~DW'(b);
            end
        end else begin
            if (serve_go) begin
                st_q[sel_addr]  <= nxt_st;
                own_q[sel_addr] <= nxt_own;
                shr_q[sel_addr] <= nxt_shr;
                if (mem_we) mem_q[sel_addr] <= mem_wd;
            end
            if (wb_hit) begin
                st_q[wb_addr]  <= DS_S;
                mem_q[wb_addr] <= wb_data;
            end
        end
    end

    // Outgoing message register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_kind  <= '0;
            out_dst   <= '0;
            out_addr  <= '0;
            out_acks  <= '0;
            out_inv   <= '0;
            out_data  <= '0;
        end else if (serve_go && m_valid) begin
            out_valid <= 1'b1;
            out_kind  <= m_kind;
            out_dst   <= m_dst;
            out_addr  <= sel_addr;
            out_acks  <= m_acks;
            out_inv   <= m_inv;
            out_data  <= m_data;
        end else begin
            out_valid <= 1'b0;
            out_kind  <= '0;
            out_dst   <= '0;
            out_addr  <= '0;
            out_acks  <= '0;
            out_inv   <= '0;
            out_data  <= '0;
        end
    end
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk
    import dir_pkg::*;
#(
    parameter int NCACHE = 4,
    localparam int IDW   = $clog2(NCACHE),
    localparam int CW    = $clog2(NCACHE + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              take,
    input logic              park,
    input logic [2:0]        req_kind,
    input logic [IDW-1:0]    req_src,
    input dstate_e           req_st,
    input logic              out_valid,
    input logic [2:0]        out_kind,
    input logic [IDW-1:0]    out_dst,
    input logic [CW-1:0]     out_acks,
    input logic [NCACHE-1:0] out_inv
);
    // R2: a read of a home-owned block is answered with data to the requester
    a_r2_read_serves_data: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !park && req_kind == RQ_GETS && (req_st == DS_I || req_st == DS_S))
        |=> (out_valid && out_kind == MS_DATA && out_dst == $past(req_src)));

    // R4: a parked request emits nothing
    a_r4_park_silent: assert property (@(posedge clk) disable iff (!rst_n)
        park |=> !out_valid);

    // R11: every release is acknowledged to its sender
    a_r11_release_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !park && (req_kind == RQ_PUTS || req_kind == RQ_PUTM || req_kind == RQ_PUTO))
        |=> (out_valid && out_kind == MS_PUT_ACK && out_dst == $past(req_src)));

    // R12: the ack count matches the invalidation set
    a_r12_acks_match_inv: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (32'(out_acks) == $countones(out_inv)));

    // R12: a requester is never told to invalidate itself
    a_r12_no_self_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_kind == MS_DATA || out_kind == MS_ACK_CNT)) |-> !out_inv[out_dst]);
endmodule

bind dir_home_top dir_home_chk #(.NCACHE(NCACHE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .park      (park),
    .req_kind  (req_kind),
    .req_src   (req_src),
    .req_st    (req_st),
    .out_valid (out_valid),
    .out_kind  (out_kind),
    .out_dst   (out_dst),
    .out_acks  (out_acks),
    .out_inv   (out_inv)
);

// File: tb/sim_dir_home_top.sv
module sim_dir_home_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       req_valid = 1'b0;
    logic [2:0] req_kind = '0;
    logic [1:0] req_src = '0, req_addr = '0;
    logic [7:0] req_data = '0;
    logic       wb_valid = 1'b0;
    logic [1:0] wb_src = '0, wb_addr = '0;
    logic [7:0] wb_data = '0;

    logic       r0, r1, v0, v1;
    logic [2:0] k0, k1, a0, a1;
    logic [1:0] d0, d1, ad0, ad1;
    logic [3:0] i0, i1;
    logic [7:0] x0, x1;

    int n_chk = 0;
    int n_bad = 0;

    dir_home_top #(.KEEP_OWNER(0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(r0),
        .req_kind(req_kind), .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
        .wb_valid(wb_valid), .wb_src(wb_src), .wb_addr(wb_addr), .wb_data(wb_data),
        .out_valid(v0), .out_kind(k0), .out_dst(d0), .out_addr(ad0),
        .out_acks(a0), .out_inv(i0), .out_data(x0));

    dir_home_top #(.KEEP_OWNER(1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(r1),
        .req_kind(req_kind), .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
        .wb_valid(wb_valid), .wb_src(wb_src), .wb_addr(wb_addr), .wb_data(wb_data),
        .out_valid(v1), .out_kind(k1), .out_dst(d1), .out_addr(ad1),
        .out_acks(a1), .out_inv(i1), .out_data(x1));

    function automatic logic [31:0] mk(input logic v, input logic [2:0] k, input logic [1:0] d,
                                       input logic [1:0] ad, input logic [2:0] n,
                                       input logic [3:0] inv, input logic [7:0] dat);
        return {9'd0, v, k, d, ad, n, inv, dat};
    endfunction

    localparam logic [31:0] NONE = 32'd0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic c0(input string tag, input logic [31:0] exp);
        chk({tag, " u0"}, mk(v0, k0, d0, ad0, a0, i0, x0), exp);
    endtask

    task automatic c1(input string tag, input logic [31:0] exp);
        chk({tag, " u1"}, mk(v1, k1, d1, ad1, a1, i1, x1), exp);
    endtask

    task automatic cb(input string tag, input logic [31:0] exp);
        c0(tag, exp);
        c1(tag, exp);
    endtask

    task automatic req(input logic [2:0] k, input logic [1:0] s, input logic [1:0] a, input logic [7:0] dat);
        req_kind = k; req_src = s; req_addr = a; req_data = dat; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wback(input logic [1:0] s, input logic [1:0] a, input logic [7:0] dat);
        wb_src = s; wb_addr = a; wb_data = dat; wb_valid = 1'b1;
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        cb("R1 reset out", NONE);
        chk("R1 ready u0", 32'(r0), 32'd1);
        chk("R1 ready u1", 32'(r1), 32'd1);

        // block 1: reads, releases, write from sharer
        req(0, 0, 1, 0); cb("R1 R2 read I", mk(1, 0, 0, 1, 0, 4'b0000, 8'hFE));
        req(0, 2, 1, 0); cb("R2 read S",    mk(1, 0, 2, 1, 0, 4'b0000, 8'hFE));
        req(2, 3, 1, 0); cb("R11 stale PutS", mk(1, 3, 3, 1, 0, 0, 0));
        req(2, 0, 1, 0); cb("R9 PutS",        mk(1, 3, 0, 1, 0, 0, 0));
        req(1, 1, 1, 0); cb("R6 R9 R11 GetM in S", mk(1, 0, 1, 1, 1, 4'b0100, 8'hFE));
        req(1, 0, 1, 0); cb("R8 GetM in M", mk(1, 2, 1, 1, 0, 0, 0));
        req(2, 2, 1, 0); cb("R11 PutS in M", mk(1, 3, 2, 1, 0, 0, 0));
        req(3, 3, 1, 8'h55); cb("R11 PutM non-owner", mk(1, 3, 3, 1, 0, 0, 0));
        req(0, 2, 1, 0); cb("R3 R5 fwd read", mk(1, 1, 0, 1, 0, 0, 0));
        req(0, 3, 1, 0);
        c0("R4 parked", NONE);
        c1("R5 fwd read in O", mk(1, 1, 0, 1, 0, 0, 0));
        wback(3, 1, 8'h11); cb("R3 stray writeback", NONE);
        wback(0, 1, 8'h77); cb("R3 owner writeback", NONE);
        @(negedge clk);
        c0("R4 replay", mk(1, 0, 3, 1, 0, 0, 8'h77));
        c1("R3 no replay", NONE);
        req(1, 1, 1, 0);
        c0("R6 GetM in S", mk(1, 0, 1, 1, 3, 4'b1101, 8'h77));
        c1("R7 fwd GetM in O", mk(1, 2, 0, 1, 2, 4'b1100, 0));
        req(3, 1, 1, 8'h99); cb("R10 PutM", mk(1, 3, 1, 1, 0, 0, 0));
        req(0, 0, 1, 0); cb("R10 memory written", mk(1, 0, 0, 1, 0, 0, 8'h99));
        req(2, 0, 1, 0); cb("R9 last PutS", mk(1, 3, 0, 1, 0, 0, 0));
        req(1, 2, 1, 0); cb("R9 block back in I", mk(1, 0, 2, 1, 0, 0, 8'h99));

        // block 2: owned release
        req(1, 0, 2, 0); cb("R6 GetM in I", mk(1, 0, 0, 2, 0, 0, 8'hFD));
        req(0, 1, 2, 0); cb("R3 R5 fwd read b2", mk(1, 1, 0, 2, 0, 0, 0));
        wback(0, 2, 8'h33); cb("R3 writeback b2", NONE);
        req(4, 0, 2, 8'h44); cb("R10 R11 PutO", mk(1, 3, 0, 2, 0, 0, 0));
        req(0, 2, 2, 0);
        c0("R11 PutO ignored in S", mk(1, 0, 2, 2, 0, 0, 8'h33));
        c1("R10 PutO written", mk(1, 0, 2, 2, 0, 0, 8'h44));

        // block 3: owner upgrade
        req(1, 0, 3, 0); cb("R6 GetM b3", mk(1, 0, 0, 3, 0, 0, 8'hFC));
        req(0, 1, 3, 0); cb("R3 fwd read b3", mk(1, 1, 0, 3, 0, 0, 0));
        wback(0, 3, 8'h21); cb("R3 writeback b3", NONE);
        req(1, 0, 3, 0);
        c0("R6 upgrade from S", mk(1, 0, 0, 3, 1, 4'b0010, 8'h21));
        c1("R7 owner upgrade", mk(1, 4, 0, 3, 1, 4'b0010, 0));

        // block 0: fill the parking queue
        req(1, 0, 0, 0); cb("R6 GetM b0", mk(1, 0, 0, 0, 0, 0, 8'hFF));
        req(0, 1, 0, 0); cb("R3 fwd read b0", mk(1, 1, 0, 0, 0, 0, 0));
        req(0, 2, 0, 0);
        c0("R4 park first", NONE);
        c1("R5 fwd b0 c2", mk(1, 1, 0, 0, 0, 0, 0));
        req(0, 3, 0, 0);
        c0("R4 park second", NONE);
        c1("R5 fwd b0 c3", mk(1, 1, 0, 0, 0, 0, 0));
        chk("R4 full stalls u0", 32'(r0), 32'd0);
        chk("R4 no stall u1", 32'(r1), 32'd1);
        wback(0, 0, 8'h66); cb("R3 writeback b0", NONE);
        chk("R4 replay stalls", 32'(r0), 32'd0);
        @(negedge clk);
        c0("R4 replay order 1", mk(1, 0, 2, 0, 0, 0, 8'h66));
        @(negedge clk);
        c0("R4 replay order 2", mk(1, 0, 3, 0, 0, 0, 8'h66));
        @(negedge clk);
        c0("R4 drained", NONE);
        chk("R4 ready again", 32'(r0), 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule